// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block watches a bank of general-purpose input pins and turns qualified level changes into sticky interrupt status bits. Each pin has its own rising-edge enable and falling-edge enable. Software programs both enables and reads or clears the status through a small single-cycle register port. Every input is first synchronised. It must then stay at a new level for a programmable number of clock cycles before that level is accepted, so short spikes and dips never reach the status logic.

A status bit is set when an accepted transition matches an enabled direction. It stays set until software writes a one to it. Pins 0 and 1 each drive an interrupt line of their own, and the status of all remaining pins is combined into one shared line. Because events come only from accepted transitions, a pin that already sits at a level does not raise status when its enable is turned on later.

Top module: `gpioEdgeIrq`

## Requirements
- R1: The register port decodes `regAddr`: 0 selects the rising-edge enables, 1 the falling-edge enables and 2 the status. A write to 0 or 1 replaces that register with `regWrData`. A read returns the register selected by the current address on `regRdData` in the same cycle, and address 3 reads as zero.
- R2: When an accepted transition matches an enabled direction on a pin, bit i of status (bit i = pin i) becomes set. It stays set in later cycles that carry no clear for that bit.
- R3: A write to address 2 clears each status bit whose `regWrData` bit is 1 and leaves every bit written with 0 unchanged.
- R4: A transition that occurs while neither enable of a pin is set is not recorded. Setting an enable afterwards while the pin is steady produces no status.
- R5: A new input level is accepted only after the synchronised input has held it for `HOLD_CYCLES` consecutive clocks. A high or low excursion of `HOLD_CYCLES-1` clocks is ignored. An accepted transition shows in status `HOLD_CYCLES+3` clock edges after the pin changes.
- R6: If a transition sets a status bit in the same cycle that a write-1 clear targets that bit, the bit ends up set.
- R7: `irqPin0` and `irqPin1` follow status bits 0 and 1. `irqShared` is high while any status bit from 2 upward is set.
- R8: Reading any register leaves the status unchanged.
- R9: After reset, both enables and the status are zero, the accepted level of every pin is low, and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Raw asynchronous input pins |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Write strobe, one cycle |
| regWrData | input | NUM_PINS | Write data |
| regRdData | output | NUM_PINS | Read data for the current address |
| irqPin0 | output | 1 | Dedicated interrupt for pin 0 |
| irqPin1 | output | 1 | Dedicated interrupt for pin 1 |
| irqShared | output | 1 | Combined interrupt for pins 2 and up |

## Verification
The bench builds the block with `NUM_PINS = 6` and `HOLD_CYCLES = 5`. With these values a pulse exactly at the threshold and one a cycle short can be told apart within a few tens of cycles. Six pins cover both dedicated lines and four pins sharing the combined line. The short threshold also makes it cheap to place a clear write in the exact cycle that a new transition lands, and it allows many random glitch-and-hold rounds.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    REG_RISE = 2'd0,
    REG_FALL = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic riseWr;
    logic fallWr;
    logic statClr;
  } ctlStrobe_t;

endpackage

// File: rtl/gpioPinQual.sv
module gpioPinQual #(
  parameter int HOLD_CYCLES = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  output logic qLevel
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic syncA, syncB;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      holdCnt <= '0;
      qLevel  <= 1'b0;
    end else begin
      syncA <= pinRaw;
      syncB <= syncA;
      if (syncB == qLevel) begin
        holdCnt <= '0;
      end else if (holdCnt == CNT_W'(HOLD_CYCLES - 1)) begin
        qLevel  <= syncB;
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  // R5: an accepted level always matches what the synchroniser showed
  p_level_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    (qLevel != $past(qLevel)) |-> ($past(syncB) == qLevel));

endmodule

// File: rtl/gpioIrqCtrl.sv
module gpioIrqCtrl
  import gpio_irq_pkg::*;
(
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  output ctlStrobe_t  strobes,
  output regSel_e     rdSel
);
  always_comb begin
    rdSel           = regSel_e'(regAddr);
    strobes         = '0;
    strobes.riseWr  = regWrEn && (rdSel == REG_RISE);
    strobes.fallWr  = regWrEn && (rdSel == REG_FALL);
    strobes.statClr = regWrEn && (rdSel == REG_STAT);
  end
endmodule

// File: rtl/gpioIrqDatapath.sv
module gpioIrqDatapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int HOLD_CYCLES = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  ctlStrobe_t          strobes,
  input  logic [NUM_PINS-1:0] wrData,
  input  regSel_e             rdSel,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] statusOut
);
  logic [NUM_PINS-1:0] riseEnQ, fallEnQ, statusQ;
  logic [NUM_PINS-1:0] qLvl, qPrev, riseSeen, fallSeen, evtHit, clrMask;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    gpioPinQual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
      .clk    (clk),
      .rstN   (rstN),
      .pinRaw (pinIn[g]),
      .qLevel (qLvl[g])
    );

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[g] && !clrMask[g]) |=> statusQ[g]);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      (clrMask[g] && !evtHit[g]) |=> !statusQ[g]);

    p_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusQ[g]) |-> $past(riseEnQ[g] || fallEnQ[g]));

    p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
      (clrMask[g] && evtHit[g]) |=> statusQ[g]);
  end

  always_comb begin
    riseSeen = qLvl & ~qPrev;
    fallSeen = ~qLvl & qPrev;
    evtHit   = (riseSeen & riseEnQ) | (fallSeen & fallEnQ);
    clrMask  = strobes.statClr ? wrData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qPrev   <= '0;
      riseEnQ <= '0;
      fallEnQ <= '0;
      statusQ <= '0;
    end else begin
      qPrev <= qLvl;
      if (strobes.riseWr) riseEnQ <= wrData;
      if (strobes.fallWr) fallEnQ <= wrData;
      statusQ <= (statusQ & ~clrMask) | evtHit;
    end
  end

  always_comb begin
    unique case (rdSel)
      REG_RISE: rdData = riseEnQ;
      REG_FALL: rdData = fallEnQ;
      REG_STAT: rdData = statusQ;
      default:  rdData = '0;
    endcase
  end

  assign statusOut = statusQ;
endmodule

// File: rtl/gpioEdgeIrq.sv
module gpioEdgeIrq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int HOLD_CYCLES = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [1:0]          regAddr,
  input  logic                regWrEn,
  input  logic [NUM_PINS-1:0] regWrData,
  output logic [NUM_PINS-1:0] regRdData,
  output logic                irqPin0,
  output logic                irqPin1,
  output logic                irqShared
);
  ctlStrobe_t          strobes;
  regSel_e             rdSel;
  logic [NUM_PINS-1:0] statusVec;

  gpioIrqCtrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  gpioIrqDatapath #(.NUM_PINS(NUM_PINS), .HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobes   (strobes),
    .wrData    (regWrData),
    .rdSel     (rdSel),
    .rdData    (regRdData),
    .statusOut (statusVec)
  );

  assign irqPin0   = statusVec[0];
  assign irqPin1   = statusVec[1];
  assign irqShared = |statusVec[NUM_PINS-1:2];

  // R7: shared line low whenever no upper status bit is held
  p_shared_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[NUM_PINS-1:2] == '0) |-> !irqShared);
endmodule

// File: tb/test_gpioEdgeIrq.sv
module test_gpioEdgeIrq;
  localparam int N = 6;
  localparam int H = 5;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] pinIn = '0;
  logic [1:0]   regAddr = 2'd0;
  logic         regWrEn = 1'b0;
  logic [N-1:0] regWrData = '0;
  logic [N-1:0] regRdData;
  logic         irqPin0, irqPin1, irqShared;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] mQual = '0, mRise = '0, mFall = '0, mStat = '0;

  gpioEdgeIrq #(.NUM_PINS(N), .HOLD_CYCLES(H)) i_gpioEdgeIrq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqPin0(irqPin0), .irqPin1(irqPin1), .irqShared(irqShared)
  );

  always #5 clk = ~clk;

  function automatic logic [N-1:0] evtCalc(logic [N-1:0] oldL, logic [N-1:0] newL,
                                           logic [N-1:0] re, logic [N-1:0] fe);
    return ((newL & ~oldL) & re) | ((~newL & oldL) & fe);
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [1:0] a, logic [N-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 2'd0) mRise = d;
    else if (a == 2'd1) mFall = d;
    else if (a == 2'd2) mStat = mStat & ~d;
  endtask

  task automatic regRead(logic [1:0] a, output logic [N-1:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic checkAll(string tag);
    logic [N-1:0] v;
    regRead(2'd2, v);
    check({tag, " R2 status"}, v, mStat);
    check({tag, " R7 irq"}, {{(N-3){1'b0}}, irqShared, irqPin1, irqPin0},
          {{(N-3){1'b0}}, |mStat[N-1:2], mStat[1], mStat[0]});
  endtask

  // drive a level on all pins, long enough to be accepted, and update the model
  task automatic settle(logic [N-1:0] lvl);
    pinIn = lvl;
    cyc(H + 6);
    mStat = mStat | evtCalc(mQual, lvl, mRise, mFall);
    mQual = lvl;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    process::self().srandom(32'd2024);
    cyc(3);
    // R9 reset state
    regRead(2'd0, v); check("R9 rise enables", v, '0);
    regRead(2'd1, v); check("R9 fall enables", v, '0);
    regRead(2'd2, v); check("R9 status", v, '0);
    check("R9 irq lines", {{(N-3){1'b0}}, irqShared, irqPin1, irqPin0}, '0);
    rstN = 1'b1;
    cyc(2);

    // R1 register access
    regWrite(2'd0, 6'b101101);
    regWrite(2'd1, 6'b010011);
    regRead(2'd0, v); check("R1 rise readback", v, 6'b101101);
    regRead(2'd1, v); check("R1 fall readback", v, 6'b010011);
    regRead(2'd3, v); check("R1 address 3 reads zero", v, '0);

    // R4 disabled edges are dropped, late enable creates nothing
    regWrite(2'd0, '0);
    regWrite(2'd1, '0);
    settle(6'b000100);
    regWrite(2'd0, 6'b000100);
    cyc(H + 6);
    checkAll("R4 no event on late enable");

    // R5 a pulse one cycle short is ignored, a threshold pulse is accepted
    regWrite(2'd0, 6'b111111);
    regWrite(2'd1, 6'b111111);
    pinIn = 6'b000101;
    cyc(H - 1);
    pinIn = 6'b000100;
    cyc(H + 6);
    checkAll("R5 short pulse ignored");
    pinIn = 6'b000101;
    cyc(H);
    pinIn = 6'b000100;
    cyc(H + 6);
    mStat = mStat | 6'b000001;
    checkAll("R5 threshold pulse gives rise and fall");
    // R5 latency: status at edge H+3 after the change
    regWrite(2'd2, '1);
    pinIn = 6'b000110;
    cyc(H + 2);
    regRead(2'd2, v); check("R5 not yet visible", v, '0);
    cyc(1);
    regRead(2'd2, v); check("R5 visible after H+3 edges", v, 6'b000010);
    mQual = 6'b000110; mStat = 6'b000010;

    // R8 reading does not clear
    regRead(2'd2, v);
    cyc(2);
    regRead(2'd2, v); check("R8 status survives reads", v, 6'b000010);

    // R3 write-1 clear, zeros ignored
    settle(6'b111110);
    regWrite(2'd2, 6'b010010);
    checkAll("R3 partial clear");

    // R6 edge and clear in the same cycle
    regWrite(2'd2, '1);
    regWrite(2'd1, '0);
    regWrite(2'd0, 6'b000001);
    pinIn = 6'b111111;
    cyc(H + 2);
    regWrite(2'd2, 6'b000001);
    mStat = 6'b000001; mQual = 6'b111111;
    cyc(1);
    regRead(2'd2, v); check("R6 edge beats clear", v, 6'b000001);
    regWrite(2'd2, 6'b000001);
    regRead(2'd2, v); check("R3 plain clear", v, '0);

    // random rounds: glitched pins revert, others hold
    regWrite(2'd0, 6'($urandom));
    regWrite(2'd1, 6'($urandom));
    for (int it = 0; it < 40; it++) begin
      logic [N-1:0] tgt, gm, newL;
      tgt = N'($urandom);
      gm  = N'($urandom);
      newL = (tgt & ~gm) | (mQual & gm);
      pinIn = tgt;
      cyc(H - 1);
      pinIn = newL;
      cyc(H + 6);
      mStat = mStat | evtCalc(mQual, newL, mRise, mFall);
      mQual = newL;
      checkAll("R2 R5 random round");
      if (it % 3 == 0) regWrite(2'd2, N'($urandom));
      if (it % 7 == 0) regWrite(2'd0, N'($urandom));
      if (it % 5 == 0) regWrite(2'd1, N'($urandom));
    end
    cyc(2);
    checkAll("R3 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule